// File: doc/BRIEF.md
# Two-Stage Multiply-Accumulate Unit with Accumulator Interlock

This block is the multiply-accumulate execution unit of a five-stage in-order pipeline (fetch, register read, execute, memory, write-back). Each cycle it can accept one operation. An operation carries two 24-bit unsigned operands, the index of the source accumulator it adds into, and the index of the destination accumulator it writes. It computes `dst = src + a * b` over a bank of four 48-bit accumulators.

The work is split over two execute stages. The multiply uses the operands at the start of the first stage (E) and is finished there. The add and the accumulator write happen in the second stage (E+1). A build-time parameter sets when the source accumulator is read. With the early read (at E), an operation that reads the accumulator written by the operation just ahead of it must wait. The unit raises a stall to the front of the pipeline for one cycle and puts a bubble into E+1. With the late read (at E+1), the value written at the end of the previous cycle is already available, so dependent operations run back to back. Write-back is visible on a dedicated port in the cycle the accumulator is written.

Top module: `mac2_pipe`

## Requirements
- R1: Synchronous active-high reset clears all four accumulators to zero and empties both stages: after reset `wb_vld` and `stall` are 0, and an operation that reads an accumulator not yet written adds into zero.
- R2: An operation writes `acc[src_acc] + op_a * op_b` (unsigned product) to accumulator `dst_acc`, and presents that index and value on `wb_idx`/`wb_data`. Results follow program order.
- R3: An operation accepted at clock edge t (`issue_vld`=1 and `stall`=0 before that edge) enters E at edge t and E+1 at edge t+1, so `wb_vld` is 1 for its result during the cycle after edge t+1. A stall adds one cycle.
- R4: With the early read (`LATE_ACC_READ`=0), an operation in E whose `src_acc` equals the `dst_acc` of the valid operation in E+1 causes `stall`=1 for exactly one cycle. During that cycle E+1 receives a bubble, so `wb_vld` is 0 in the next cycle. The result is computed from the updated accumulator.
- R5: With the late read (`LATE_ACC_READ`=1), `stall` is never raised, and dependent operations issued on consecutive cycles produce results on consecutive cycles with correct values.
- R6: An operation whose `src_acc` differs from the `dst_acc` of the operation ahead of it never stalls, in either mode.
- R7: While `stall` is 1, the inputs are not taken. The operation held in E keeps its contents, and an operation presented on the inputs is accepted once, on the first edge with `stall`=0.
- R8: Accumulation wraps modulo 2^48.
- R9: In cycles with no operation in E+1, `wb_vld` is 0 and no accumulator is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | An operation is presented this cycle |
| op_a | input | 24 | Multiplicand (unsigned) |
| op_b | input | 24 | Multiplier (unsigned) |
| src_acc | input | 2 | Accumulator index added into |
| dst_acc | input | 2 | Accumulator index written |
| stall | output | 1 | Front of pipeline must hold its operation this cycle |
| wb_vld | output | 1 | An accumulator is written at the end of this cycle |
| wb_idx | output | 2 | Index of the accumulator being written |
| wb_data | output | 48 | Value being written |

## Verification
The bench drives one instance of each read mode with back-to-back dependent chains. An early-read design without the interlock would add into the stale accumulator. A late-read design that stalled anyway would shift every result by a cycle. The bench holds an operation on the inputs through a stall; a unit that took it twice would produce an extra write-back, and one that dropped the E-stage operation would miss one. It also checks independent back-to-back pairs, which must not lose a cycle, and repeated full-scale products, which must wrap at 48 bits. A model in the bench predicts every write-back's value and its cycle. Randomised operations with random gaps then mix these cases.

// File: rtl/mac2_pkg.sv
package mac2_pkg;
    localparam int OP_W   = 24;
    localparam int ACC_W  = 48;
    localparam int N_ACC  = 4;
    localparam int IDX_W  = $clog2(N_ACC);
    localparam int PROD_W = 2 * OP_W;

    typedef logic [IDX_W-1:0] acc_idx_t;
    typedef logic [ACC_W-1:0] acc_t;
    typedef logic [PROD_W-1:0] prod_t;

    // operation sitting in the first execute stage
    typedef struct packed {
        logic            vld;
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        acc_idx_t        src;
        acc_idx_t        dst;
    } e_slot_t;

    // operation sitting in the second execute stage
    typedef struct packed {
        logic     vld;
        prod_t    prod;
        acc_t     acc_early;
        acc_idx_t src;
        acc_idx_t dst;
    } x_slot_t;

    function automatic prod_t mac_product(logic [OP_W-1:0] a, logic [OP_W-1:0] b);
        return prod_t'(a) * prod_t'(b);
    endfunction

    function automatic acc_t mac_sum(acc_t acc, prod_t p);
        return acc + acc_t'(p);
    endfunction
endpackage

// File: rtl/mac2_acc_file.sv
module mac2_acc_file
    import mac2_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  acc_idx_t widx,
    input  acc_t     wdata,
    input  acc_idx_t ridx,
    output acc_t     rdata
);
    acc_t ent [N_ACC];

    for (genvar i = 0; i < N_ACC; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[i] <= '0;
            else if (we && widx == acc_idx_t'(i))
                ent[i] <= wdata;
        end
    end

    assign rdata = ent[ridx];
endmodule

// File: rtl/mac2_hazard.sv
module mac2_hazard
    import mac2_pkg::*;
#(
    parameter bit LATE_ACC_READ = 1'b1
) (
    input  logic     e_vld,
    input  acc_idx_t e_src,
    input  logic     x_vld,
    input  acc_idx_t x_dst,
    output logic     stall
);
    // only the early read needs the interlock
    assign stall = !LATE_ACC_READ && e_vld && x_vld && (e_src == x_dst);
endmodule

// File: rtl/mac2_pipe.sv
module mac2_pipe
    import mac2_pkg::*;
#(
    parameter bit LATE_ACC_READ = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_vld,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [IDX_W-1:0]  src_acc,
    input  logic [IDX_W-1:0]  dst_acc,
    output logic              stall,
    output logic              wb_vld,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [ACC_W-1:0]  wb_data
);
    e_slot_t  e_q;
    x_slot_t  x_q, x_next;
    acc_t     rd_data, acc_in, sum;
    acc_idx_t rd_idx;

    mac2_hazard #(.LATE_ACC_READ(LATE_ACC_READ)) u_haz (
        .e_vld (e_q.vld),
        .e_src (e_q.src),
        .x_vld (x_q.vld),
        .x_dst (x_q.dst),
        .stall (stall)
    );

    // single read port: E-stage source (early) or E+1-stage source (late)
    assign rd_idx = LATE_ACC_READ ? x_q.src : e_q.src;

    mac2_acc_file u_acc (
        .clk   (clk),
        .rst   (rst),
        .we    (x_q.vld),
        .widx  (x_q.dst),
        .wdata (sum),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    // E stage: multiply
    always_comb begin
        x_next.vld       = e_q.vld;
        x_next.prod      = mac_product(e_q.a, e_q.b);
        x_next.acc_early = rd_data;
        x_next.src       = e_q.src;
        x_next.dst       = e_q.dst;
    end

    // E+1 stage: add
    assign acc_in = LATE_ACC_READ ? rd_data : x_q.acc_early;
    assign sum    = mac_sum(acc_in, x_q.prod);

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= '0;
            x_q <= '0;
        end else begin
            if (!stall)
                e_q <= '{vld: issue_vld, a: op_a, b: op_b, src: src_acc, dst: dst_acc};
            x_q <= stall ? '0 : x_next;
        end
    end

    assign wb_vld  = x_q.vld;
    assign wb_idx  = x_q.dst;
    assign wb_data = sum;

    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> (!wb_vld && !e_q.vld && !stall));

    p_stage_advance_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(e_q.vld) && !$past(stall)) |-> wb_vld);

    p_stall_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        stall |=> !wb_vld);

    p_single_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    p_indep_no_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (e_q.vld && x_q.vld && e_q.src != x_q.dst) |-> !stall);

    p_hold_e_r7: assert property (@(posedge clk) disable iff (rst)
        stall |=> (e_q.vld && $stable(e_q)));
endmodule

// File: tb/tb_mac2_pipe.sv
module tb_mac2_pipe;
    import mac2_pkg::*;

    localparam int CLK_P = 10;

    typedef struct {
        int       t;
        acc_idx_t idx;
        acc_t     data;
        string    tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst;
    always #(CLK_P/2) clk = ~clk;

    logic            i_vld [2];
    logic [OP_W-1:0] i_a   [2];
    logic [OP_W-1:0] i_b   [2];
    acc_idx_t        i_src [2];
    acc_idx_t        i_dst [2];
    logic            st    [2];
    logic            wv    [2];
    acc_idx_t        wi    [2];
    acc_t            wd    [2];

    mac2_pipe #(.LATE_ACC_READ(1'b1)) dut (
        .clk(clk), .rst(rst), .issue_vld(i_vld[0]), .op_a(i_a[0]), .op_b(i_b[0]),
        .src_acc(i_src[0]), .dst_acc(i_dst[0]), .stall(st[0]), .wb_vld(wv[0]),
        .wb_idx(wi[0]), .wb_data(wd[0]));

    mac2_pipe #(.LATE_ACC_READ(1'b0)) dut_early (
        .clk(clk), .rst(rst), .issue_vld(i_vld[1]), .op_a(i_a[1]), .op_b(i_b[1]),
        .src_acc(i_src[1]), .dst_acc(i_dst[1]), .stall(st[1]), .wb_vld(wv[1]),
        .wb_idx(wi[1]), .wb_data(wd[1]));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    exp_t q0[$];
    exp_t q1[$];
    acc_t m_acc [2][N_ACC];
    int   prev_t [2];
    int   prev_s [2];
    acc_idx_t prev_dst [2];
    bit   prev_has [2];
    int   exp_stalls [2];
    int   obs_stalls [2];

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // called at a negedge; returns at the negedge after acceptance, inputs still driven
    task automatic issue(input int m, input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                         input acc_idx_t s, input acc_idx_t d, input string tag);
        bit held;
        bit adj;
        int es;
        int t;
        acc_t nv;
        exp_t e;
        i_vld[m] = 1'b1; i_a[m] = a; i_b[m] = b; i_src[m] = s; i_dst[m] = d;
        do begin
            held = st[m];
            @(negedge clk);
        end while (held);
        t   = cyc;
        adj = prev_has[m] && (prev_t[m] + 1 + prev_s[m] == t);
        es  = (m == 1 && adj && s == prev_dst[m]) ? 1 : 0;
        nv  = m_acc[m][s] + acc_t'(a) * acc_t'(b);
        m_acc[m][d] = nv;
        e.t = t + 1 + es; e.idx = d; e.data = nv; e.tag = tag;
        if (m == 0) q0.push_back(e); else q1.push_back(e);
        exp_stalls[m] += es;
        prev_t[m] = t; prev_s[m] = es; prev_dst[m] = d; prev_has[m] = 1'b1;
    endtask

    task automatic idle(input int m, input int n);
        i_vld[m] = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // write-back monitor for both instances
    always @(negedge clk) begin
        if (!rst) begin
            for (int m = 0; m < 2; m++) begin
                exp_t e;
                if (st[m]) obs_stalls[m]++;
                if (wv[m]) begin
                    if ((m == 0 && q0.size() == 0) || (m == 1 && q1.size() == 0)) begin
                        check(1'b0, "R9", "unexpected write-back", 64'(wd[m]), 64'd0);
                    end else begin
                        e = (m == 0) ? q0.pop_front() : q1.pop_front();
                        check(wi[m] == e.idx && wd[m] == e.data, e.tag, "write-back value",
                              {14'd0, wi[m], wd[m]}, {14'd0, e.idx, e.data});
                        check(cyc == e.t, "R3", "write-back cycle", 64'(cyc), 64'(e.t));
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int m = 0; m < 2; m++) begin
            i_vld[m] = 1'b0; i_a[m] = '0; i_b[m] = '0; i_src[m] = '0; i_dst[m] = '0;
            prev_has[m] = 1'b0; prev_t[m] = 0; prev_s[m] = 0; prev_dst[m] = '0;
            exp_stalls[m] = 0; obs_stalls[m] = 0;
            for (int k = 0; k < N_ACC; k++) m_acc[m][k] = '0;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < 2; m++) begin
            check(!wv[m], "R1", "wb_vld after reset", 64'(wv[m]), 64'd0);
            check(!st[m], "R1", "stall after reset", 64'(st[m]), 64'd0);
        end

        for (int m = 0; m < 2; m++) begin
            // R1: unwritten accumulator reads zero
            issue(m, 24'd3, 24'd5, 2'd0, 2'd0, "R1");
            idle(m, 3);
            // dependent chain; third op is held through the early-mode stall (R7)
            issue(m, 24'd7, 24'd11, 2'd1, 2'd1, "R2");
            issue(m, 24'd2, 24'd3, 2'd1, 2'd1, (m == 1) ? "R4" : "R5");
            issue(m, 24'd1, 24'd1, 2'd1, 2'd2, "R7");
            idle(m, 3);
            // independent back-to-back pair
            issue(m, 24'd4, 24'd4, 2'd0, 2'd3, "R6");
            issue(m, 24'd5, 24'd5, 2'd1, 2'd2, "R6");
            issue(m, 24'd6, 24'd6, 2'd3, 2'd0, "R6");
            idle(m, 3);
            // wrap at 48 bits
            issue(m, 24'hFFFFFF, 24'hFFFFFF, 2'd3, 2'd3, "R8");
            issue(m, 24'hFFFFFF, 24'hFFFFFF, 2'd3, 2'd3, "R8");
            issue(m, 24'hFFFFFF, 24'hFFFFFF, 2'd3, 2'd3, "R8");
            idle(m, 3);
            check(!wv[m], "R9", "wb_vld while idle", 64'(wv[m]), 64'd0);
            // random mix
            for (int n = 0; n < 300; n++) begin
                logic [OP_W-1:0] ra;
                logic [OP_W-1:0] rb;
                acc_idx_t rs;
                acc_idx_t rdst;
                int gap;
                ra   = (($urandom() & 7) == 0) ? 24'hFFFFFF : OP_W'($urandom());
                rb   = OP_W'($urandom());
                rs   = acc_idx_t'($urandom_range(0, N_ACC - 1));
                rdst = acc_idx_t'($urandom_range(0, N_ACC - 1));
                issue(m, ra, rb, rs, rdst, "R2");
                gap = $urandom_range(0, 3);
                if (gap == 3) idle(m, 1 + int'($urandom_range(0, 2)));
            end
            idle(m, 5);
            check(((m == 0) ? q0.size() : q1.size()) == 0, "R3", "pending write-backs",
                  64'((m == 0) ? q0.size() : q1.size()), 64'd0);
            check(obs_stalls[m] == exp_stalls[m], (m == 1) ? "R4" : "R5", "stall cycle count",
                  64'(obs_stalls[m]), 64'(exp_stalls[m]));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule